// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block decides, every cycle, whether a hart enters a trap and where it goes. It handles three kinds of entry: resumable non-maskable interrupts (RNMI), ordinary interrupts, and synchronous exceptions. RNMI request lines are level inputs that feed a pending register. Whenever the NMI-enable bit (NMIE) is set, a pending RNMI takes precedence over any ordinary interrupt. An RNMI saves its state into a dedicated NMI register set: status fields, cause and exception PC. It leaves the machine trap registers alone.

Ordinary traps take one of three targets:
- the supervisor vector, when the single delegate input applies;
- the machine vector, in direct or vectored form;
- the RNMI exception vector, for a synchronous exception that is handled in machine mode while NMIE is clear.

The block is combinational from its request inputs to its take strobe and next-PC outputs. Its state registers update on the clock edge that ends the take cycle.

The caller qualifies the ordinary interrupt request (`irq_valid`, `irq_cause`) against its own enable and priority logic before presenting it.

Top module: `rnmi_trap_ctrl`

## Requirements
- R1: The pending vector `rnmi_pend` equals the value of `rnmi_req` sampled at the previous clock edge. Asserting line i sets bit i, and dropping it clears bit i. Both `rnmi_pend` and NMIE reset to 0.
- R2: While NMIE is 0, no interrupt is taken, whether RNMI or ordinary. `take` only rises for a synchronous exception.
- R3: When NMIE is 1 and any pending bit is set, an RNMI is taken ahead of any ordinary interrupt. Its cause code is the index of the lowest-numbered set pending bit.
- R4: Taking an RNMI has these effects:
  - `next_pc` is `nmi_vec`, `next_priv` is 2'b11 (machine) and `next_virt` is 0;
  - on the following edge, NMIE becomes 0, `mnpv` becomes `cur_virt` and `mnpp` becomes `cur_priv`;
  - `mncause` becomes the cause with bit XLEN-1 set, and `mnepc` becomes `cur_pc`.
- R5: An RNMI entry leaves `mcause`, `mepc`, `mtval`, `mpp` and `mie` unchanged.
- R6: A synchronous exception that is not delegated, taken while NMIE is 0, sends `next_pc` to `nmi_exc_vec`. It still updates `mcause`, `mepc`, `mtval`, `mpp` and `mie` as a machine trap does.
- R7: A machine-mode trap whose target is the machine vector sets `next_pc` to `mtvec` with bits [1:0] cleared. If the trap is an interrupt and `mtvec[1:0]` is 1, the cause times 4 is added.
- R8: On a machine-mode trap the following registers update:
  - `mcause` gets the async flag in bit XLEN-1 and the 6-bit cause in its low bits;
  - `mepc` gets `cur_pc`;
  - `mtval` gets `exc_tval` for an exception and 0 for an interrupt;
  - `mpp` gets `cur_priv`, and `mie` becomes 0.
- R9: A synchronous exception (`exc_valid`) wins over every interrupt, RNMI included, in the same cycle.
- R10: With `cur_priv` of 2'b00 or 2'b01 and `deleg_s` high, an exception or ordinary interrupt goes to supervisor mode. In that case:
  - `next_priv` is 2'b01 and `next_virt` is `cur_virt`;
  - `next_pc` is `stvec` with bits [1:0] cleared, plus cause times 4 for an interrupt when `stvec[1:0]` is 1;
  - no machine or NMI register changes.
- R11: `nmie_set` sets NMIE on the next edge unless an RNMI is taken in that cycle. `mie_set` sets `mie` unless a machine trap is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnmi_req | input | NLINES | Level RNMI request lines |
| irq_valid | input | 1 | Qualified ordinary interrupt request |
| irq_cause | input | 6 | Ordinary interrupt cause code |
| exc_valid | input | 1 | Synchronous exception request |
| exc_cause | input | 6 | Exception cause code |
| exc_tval | input | XLEN | Exception trap value |
| deleg_s | input | 1 | Delegate this trap to supervisor mode |
| cur_pc | input | XLEN | Current program counter |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Current virtualization state |
| mtvec | input | XLEN | Machine trap vector |
| stvec | input | XLEN | Supervisor trap vector |
| nmi_vec | input | XLEN | RNMI interrupt handler address |
| nmi_exc_vec | input | XLEN | RNMI exception handler address |
| nmie_set | input | 1 | Set NMIE |
| mie_set | input | 1 | Set machine interrupt enable |
| take | output | 1 | Trap taken this cycle |
| next_pc | output | XLEN | Target PC when take is high |
| next_priv | output | 2 | Target privilege |
| next_virt | output | 1 | Target virtualization state |
| rnmi_pend | output | NLINES | RNMI pending vector |
| nmie | output | 1 | NMI enable |
| mnpp | output | 2 | Privilege saved at RNMI entry |
| mnpv | output | 1 | Virtualization saved at RNMI entry |
| mncause | output | XLEN | NMI cause |
| mnepc | output | XLEN | NMI exception PC |
| mcause | output | XLEN | Machine cause |
| mepc | output | XLEN | Machine exception PC |
| mtval | output | XLEN | Machine trap value |
| mpp | output | 2 | Machine previous privilege |
| mie | output | 1 | Machine interrupt enable |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- **Pending RNMI with NMIE clear.** A design that ignores the gate retakes the RNMI every cycle and overwrites `mnepc`.
- **Several pending lines at once.** A wrong encoder reports the highest index instead of the lowest.
- **Exception in machine mode with NMIE clear.** A design that misroutes it jumps to `mtvec`, or skips the `mcause`/`mepc` update.
- **RNMI, interrupt and exception in one cycle.** An arbiter ordered wrongly lets the RNMI steal the exception cycle.
- **Vectored mode applied to exceptions.** A design that adds the offset for exceptions lands beyond the vector base.
- **Delegated traps.** A design that ignores delegation writes the machine registers.

The bench also runs a long stretch of random stimulus against its reference model.

// File: rtl/rnmi_trap_pkg.sv
package rnmi_trap_pkg;
   localparam int CAUSE_W = 6;

   typedef enum logic [1:0] {
      PRIV_U = 2'd0,
      PRIV_S = 2'd1,
      PRIV_M = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      TK_NONE = 2'd0,
      TK_EXC  = 2'd1,
      TK_RNMI = 2'd2,
      TK_IRQ  = 2'd3
   } take_e;
endpackage

// File: rtl/rnmi_pend.sv
module rnmi_pend #(
   parameter int NLINES = 8,
   parameter int IW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] req,
   output logic [NLINES-1:0] pend,
   output logic              any,
   output logic [IW-1:0]     idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= req;
   end

   assign any = |pend;

   // lowest-numbered set bit wins: scan downward so the last hit is lowest
   always_comb begin
      idx = '0;
      for (int i = NLINES - 1; i >= 0; i--) begin
         if (pend[i]) idx = IW'(i);
      end
   end

   // R1
   pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> pend == $past(req));
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import rnmi_trap_pkg::*;
#(
   parameter bit RNMI_ON = 1'b1
) (
   input  logic  exc_valid,
   input  logic  irq_valid,
   input  logic  rnmi_any,
   input  logic  nmie,
   output take_e kind
);
   logic int_gate;
   logic rnmi_hit;

   generate
      if (RNMI_ON) begin : g_gated
         assign int_gate = nmie;
         assign rnmi_hit = rnmi_any;
      end else begin : g_plain
         assign int_gate = 1'b1;
         assign rnmi_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (exc_valid)                  kind = TK_EXC;
      else if (int_gate && rnmi_hit)  kind = TK_RNMI;
      else if (int_gate && irq_valid) kind = TK_IRQ;
      else                            kind = TK_NONE;
   end

   // R9
   exc_first_chk: assert final (!exc_valid || kind == TK_EXC);
endmodule

// File: rtl/trap_target.sv
module trap_target
   import rnmi_trap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter bit RNMI_ON = 1'b1
) (
   input  take_e              kind,
   input  logic [CAUSE_W-1:0] cause,
   input  logic [1:0]         cur_priv,
   input  logic               cur_virt,
   input  logic               deleg_s,
   input  logic               nmie,
   input  logic [XLEN-1:0]    mtvec,
   input  logic [XLEN-1:0]    stvec,
   input  logic [XLEN-1:0]    nmi_vec,
   input  logic [XLEN-1:0]    nmi_exc_vec,
   output logic [XLEN-1:0]    next_pc,
   output logic [1:0]         next_priv,
   output logic               next_virt,
   output logic               to_s,
   output logic               to_m
);
   localparam int PAD_W = XLEN - CAUSE_W - 2;

   logic            async_t;
   logic            ordinary;
   logic            nmi_exc;
   logic [XLEN-1:0] vec_off;

   assign async_t  = (kind == TK_IRQ);
   assign ordinary = (kind == TK_EXC) || (kind == TK_IRQ);
   assign to_s     = ordinary && (cur_priv != PRIV_M) && deleg_s;
   assign to_m     = ordinary && !to_s;
   assign vec_off  = {{PAD_W{1'b0}}, cause, 2'b00};

   generate
      if (RNMI_ON) begin : g_nmi_exc
         assign nmi_exc = (kind == TK_EXC) && !to_s && !nmie;
      end else begin : g_no_nmi_exc
         assign nmi_exc = 1'b0;
      end
   endgenerate

   always_comb begin
      next_pc   = '0;
      next_priv = PRIV_M;
      next_virt = 1'b0;
      if (kind == TK_RNMI) begin
         next_pc = nmi_vec;
      end else if (to_s) begin
         next_pc   = {stvec[XLEN-1:2], 2'b00} +
                     ((async_t && stvec[1:0] == 2'd1) ? vec_off : '0);
         next_priv = PRIV_S;
         next_virt = cur_virt;
      end else if (nmi_exc) begin
         next_pc = nmi_exc_vec;
      end else if (to_m) begin
         next_pc = {mtvec[XLEN-1:2], 2'b00} +
                   ((async_t && mtvec[1:0] == 2'd1) ? vec_off : '0);
      end
   end

   // R6
   nmi_exc_vec_chk: assert final (!(RNMI_ON && kind == TK_EXC && to_m && !nmie) ||
                                  next_pc == nmi_exc_vec);
endmodule

// File: rtl/rnmi_trap_ctrl.sv
module rnmi_trap_ctrl
   import rnmi_trap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int NLINES  = 8,
   parameter bit RNMI_ON = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NLINES-1:0]  rnmi_req,
   input  logic               irq_valid,
   input  logic [5:0]         irq_cause,
   input  logic               exc_valid,
   input  logic [5:0]         exc_cause,
   input  logic [XLEN-1:0]    exc_tval,
   input  logic               deleg_s,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic [1:0]         cur_priv,
   input  logic               cur_virt,
   input  logic [XLEN-1:0]    mtvec,
   input  logic [XLEN-1:0]    stvec,
   input  logic [XLEN-1:0]    nmi_vec,
   input  logic [XLEN-1:0]    nmi_exc_vec,
   input  logic               nmie_set,
   input  logic               mie_set,
   output logic               take,
   output logic [XLEN-1:0]    next_pc,
   output logic [1:0]         next_priv,
   output logic               next_virt,
   output logic [NLINES-1:0]  rnmi_pend,
   output logic               nmie,
   output logic [1:0]         mnpp,
   output logic               mnpv,
   output logic [XLEN-1:0]    mncause,
   output logic [XLEN-1:0]    mnepc,
   output logic [XLEN-1:0]    mcause,
   output logic [XLEN-1:0]    mepc,
   output logic [XLEN-1:0]    mtval,
   output logic [1:0]         mpp,
   output logic               mie
);
   localparam int IW    = (NLINES > 1) ? $clog2(NLINES) : 1;
   localparam int PAD_W = XLEN - 1 - CAUSE_W;

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("rnmi_trap_ctrl: XLEN must be 32 or 64");
      end
      if (NLINES < 1 || NLINES > 32) begin : g_bad_nlines
         $error("rnmi_trap_ctrl: NLINES must be 1..32");
      end
   endgenerate

   logic               rnmi_any;
   logic [IW-1:0]      rnmi_idx;
   take_e              kind;
   logic [CAUSE_W-1:0] cause;
   logic               to_s;
   logic               to_m;

   rnmi_pend #(.NLINES(NLINES), .IW(IW)) u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (rnmi_req),
      .pend (rnmi_pend),
      .any  (rnmi_any),
      .idx  (rnmi_idx)
   );

   trap_arbiter #(.RNMI_ON(RNMI_ON)) u_arb (
      .exc_valid(exc_valid),
      .irq_valid(irq_valid),
      .rnmi_any (rnmi_any),
      .nmie     (nmie),
      .kind     (kind)
   );

   always_comb begin
      unique case (kind)
         TK_EXC:  cause = exc_cause;
         TK_IRQ:  cause = irq_cause;
         TK_RNMI: cause = CAUSE_W'(rnmi_idx);
         default: cause = '0;
      endcase
   end

   trap_target #(.XLEN(XLEN), .RNMI_ON(RNMI_ON)) u_tgt (
      .kind       (kind),
      .cause      (cause),
      .cur_priv   (cur_priv),
      .cur_virt   (cur_virt),
      .deleg_s    (deleg_s),
      .nmie       (nmie),
      .mtvec      (mtvec),
      .stvec      (stvec),
      .nmi_vec    (nmi_vec),
      .nmi_exc_vec(nmi_exc_vec),
      .next_pc    (next_pc),
      .next_priv  (next_priv),
      .next_virt  (next_virt),
      .to_s       (to_s),
      .to_m       (to_m)
   );

   assign take = (kind != TK_NONE);

   // NMI register set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmie    <= 1'b0;
         mnpp    <= 2'd0;
         mnpv    <= 1'b0;
         mncause <= '0;
         mnepc   <= '0;
      end else if (kind == TK_RNMI) begin
         nmie    <= 1'b0;
         mnpp    <= cur_priv;
         mnpv    <= cur_virt;
         mncause <= {1'b1, {PAD_W{1'b0}}, cause};
         mnepc   <= cur_pc;
      end else if (nmie_set) begin
         nmie    <= 1'b1;
      end
   end

   // machine trap register set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcause <= '0;
         mepc   <= '0;
         mtval  <= '0;
         mpp    <= 2'd0;
         mie    <= 1'b0;
      end else if (to_m) begin
         mcause <= {kind == TK_IRQ, {PAD_W{1'b0}}, cause};
         mepc   <= cur_pc;
         mtval  <= (kind == TK_EXC) ? exc_tval : '0;
         mpp    <= cur_priv;
         mie    <= 1'b0;
      end else if (mie_set) begin
         mie    <= 1'b1;
      end
   end

   // R2
   nmie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (RNMI_ON && !nmie && take) |-> exc_valid);

   // R4
   rnmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !exc_valid && rnmi_any && nmie) |=>
         (!nmie && mncause[XLEN-1] && mnepc == $past(cur_pc)));

   // R5
   rnmi_keeps_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == TK_RNMI) |=> ($stable(mcause) && $stable(mepc) && $stable(mtval)));

   // R10
   deleg_keeps_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      to_s |=> ($stable(mepc) && $stable(mnepc)));
endmodule

// File: tb/rnmi_trap_ctrl_test.sv
module rnmi_trap_ctrl_test;
   localparam int XLEN = 32;
   localparam int NL   = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NL-1:0]   rnmi_req = '0;
   logic            irq_valid = 1'b0;
   logic [5:0]      irq_cause = '0;
   logic            exc_valid = 1'b0;
   logic [5:0]      exc_cause = '0;
   logic [XLEN-1:0] exc_tval = '0;
   logic            deleg_s = 1'b0;
   logic [XLEN-1:0] cur_pc = 32'h0000_1000;
   logic [1:0]      cur_priv = 2'd3;
   logic            cur_virt = 1'b0;
   logic [XLEN-1:0] mtvec = 32'h0000_8000;
   logic [XLEN-1:0] stvec = 32'h0000_4000;
   logic [XLEN-1:0] nmi_vec = 32'h0000_0100;
   logic [XLEN-1:0] nmi_exc_vec = 32'h0000_0200;
   logic            nmie_set = 1'b0;
   logic            mie_set = 1'b0;

   logic            take;
   logic [XLEN-1:0] next_pc;
   logic [1:0]      next_priv;
   logic            next_virt;
   logic [NL-1:0]   rnmi_pend;
   logic            nmie;
   logic [1:0]      mnpp;
   logic            mnpv;
   logic [XLEN-1:0] mncause, mnepc, mcause, mepc, mtval;
   logic [1:0]      mpp;
   logic            mie;

   rnmi_trap_ctrl #(.XLEN(XLEN), .NLINES(NL), .RNMI_ON(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .rnmi_req(rnmi_req), .irq_valid(irq_valid),
      .irq_cause(irq_cause), .exc_valid(exc_valid), .exc_cause(exc_cause),
      .exc_tval(exc_tval), .deleg_s(deleg_s), .cur_pc(cur_pc),
      .cur_priv(cur_priv), .cur_virt(cur_virt), .mtvec(mtvec), .stvec(stvec),
      .nmi_vec(nmi_vec), .nmi_exc_vec(nmi_exc_vec), .nmie_set(nmie_set),
      .mie_set(mie_set), .take(take), .next_pc(next_pc), .next_priv(next_priv),
      .next_virt(next_virt), .rnmi_pend(rnmi_pend), .nmie(nmie), .mnpp(mnpp),
      .mnpv(mnpv), .mncause(mncause), .mnepc(mnepc), .mcause(mcause),
      .mepc(mepc), .mtval(mtval), .mpp(mpp), .mie(mie)
   );

   always #5 clk = ~clk;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // reference model state
   logic [NL-1:0]   m_pend = '0;
   logic            m_nmie = 1'b0, m_mnpv = 1'b0, m_mie = 1'b0;
   logic [1:0]      m_mnpp = '0, m_mpp = '0;
   logic [XLEN-1:0] m_mncause = '0, m_mnepc = '0, m_mcause = '0, m_mepc = '0, m_mtval = '0;

   task automatic chk(input string tag, input string name,
                      input logic [63:0] got, input logic [63:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, got, exp, $time);
      end
   endtask

   // kind: 0 none, 1 exception, 2 rnmi, 3 interrupt
   task automatic step();
      int kind, lo;
      logic [5:0] cs;
      bit to_s, to_m, nexc;
      logic [XLEN-1:0] epc;
      #4;
      lo = -1;
      for (int i = 0; i < NL; i++) if (m_pend[i] && lo < 0) lo = i;
      if (exc_valid) kind = 1;
      else if (m_nmie && lo >= 0) kind = 2;
      else if (m_nmie && irq_valid) kind = 3;
      else kind = 0;
      cs   = (kind == 1) ? exc_cause : (kind == 3) ? irq_cause : (kind == 2) ? 6'(lo) : 6'd0;
      to_s = (kind == 1 || kind == 3) && cur_priv != 2'd3 && deleg_s;
      to_m = (kind == 1 || kind == 3) && !to_s;
      nexc = kind == 1 && to_m && !m_nmie;
      // state outputs from model
      chk("R1", "rnmi_pend", 64'(rnmi_pend), 64'(m_pend));
      chk("R11", "nmie", 64'(nmie), 64'(m_nmie));
      chk("R4", "mnpp", 64'(mnpp), 64'(m_mnpp));
      chk("R4", "mnpv", 64'(mnpv), 64'(m_mnpv));
      chk("R4", "mncause", 64'(mncause), 64'(m_mncause));
      chk("R4", "mnepc", 64'(mnepc), 64'(m_mnepc));
      chk("R8", "mcause", 64'(mcause), 64'(m_mcause));
      chk("R8", "mepc", 64'(mepc), 64'(m_mepc));
      chk("R8", "mtval", 64'(mtval), 64'(m_mtval));
      chk("R8", "mpp", 64'(mpp), 64'(m_mpp));
      chk("R8", "mie", 64'(mie), 64'(m_mie));
      chk("R2", "take", 64'(take), 64'(kind != 0));
      if (kind == 2) begin
         chk("R4", "next_pc", 64'(next_pc), 64'(nmi_vec));
         chk("R4", "next_priv", 64'(next_priv), 64'd3);
         chk("R4", "next_virt", 64'(next_virt), 64'd0);
      end else if (to_s) begin
         epc = {stvec[XLEN-1:2], 2'b00};
         if (kind == 3 && stvec[1:0] == 2'd1) epc = epc + XLEN'(cs) * 4;
         chk("R10", "next_pc", 64'(next_pc), 64'(epc));
         chk("R10", "next_priv", 64'(next_priv), 64'd1);
         chk("R10", "next_virt", 64'(next_virt), 64'(cur_virt));
      end else if (nexc) begin
         chk("R6", "next_pc", 64'(next_pc), 64'(nmi_exc_vec));
         chk("R6", "next_priv", 64'(next_priv), 64'd3);
      end else if (to_m) begin
         epc = {mtvec[XLEN-1:2], 2'b00};
         if (kind == 3 && mtvec[1:0] == 2'd1) epc = epc + XLEN'(cs) * 4;
         chk("R7", "next_pc", 64'(next_pc), 64'(epc));
         chk("R7", "next_priv", 64'(next_priv), 64'd3);
         chk("R7", "next_virt", 64'(next_virt), 64'd0);
      end
      @(posedge clk);
      // model update at the edge
      m_pend = rnmi_req;
      if (kind == 2) begin
         m_nmie = 1'b0; m_mnpp = cur_priv; m_mnpv = cur_virt;
         m_mncause = (XLEN'(1) << (XLEN - 1)) | XLEN'(cs);
         m_mnepc = cur_pc;
      end else if (nmie_set) m_nmie = 1'b1;
      if (to_m) begin
         m_mcause = ((kind == 3) ? (XLEN'(1) << (XLEN - 1)) : '0) | XLEN'(cs);
         m_mepc = cur_pc;
         m_mtval = (kind == 1) ? exc_tval : '0;
         m_mpp = cur_priv;
         m_mie = 1'b0;
      end else if (mie_set) m_mie = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle();
      rnmi_req = '0; irq_valid = 0; exc_valid = 0; deleg_s = 0;
      nmie_set = 0; mie_set = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state, R1 R2
      step();
      // R2: requests with NMIE clear are not taken
      rnmi_req = 8'h81; irq_valid = 1; irq_cause = 6'd7;
      step(); step();
      // R1: dropping lines clears pending
      rnmi_req = 8'h00; step(); step();
      // R11: set NMIE and MIE
      irq_valid = 0; nmie_set = 1; mie_set = 1; step();
      nmie_set = 0; mie_set = 0;
      // R3 R4 R5: lowest line wins over an ordinary interrupt
      rnmi_req = 8'h68; step();
      irq_valid = 1; irq_cause = 6'd11; cur_pc = 32'h0000_2224; cur_priv = 2'd1; cur_virt = 1;
      step();
      irq_valid = 0; step();
      // R6: M exception with NMIE clear goes to the NMI exception vector
      rnmi_req = 0; cur_priv = 2'd3; cur_virt = 0;
      exc_valid = 1; exc_cause = 6'd2; exc_tval = 32'hdead_beef; cur_pc = 32'h0000_3330;
      step();
      exc_valid = 0; nmie_set = 1; step(); nmie_set = 0;
      // R7: vectored and direct machine vector
      mtvec = 32'h0000_8001; irq_valid = 1; irq_cause = 6'd9; step();
      mtvec = 32'h0000_8000; step();
      irq_valid = 0; mtvec = 32'h0000_8001;
      exc_valid = 1; exc_cause = 6'd5; step(); // R7 no offset for exceptions
      // R9: exception beats RNMI and interrupt together
      rnmi_req = 8'h02; step();
      irq_valid = 1; exc_cause = 6'd13; step();
      // R10: delegated traps from U
      idle(); cur_priv = 2'd0; deleg_s = 1; stvec = 32'h0000_4001;
      irq_valid = 1; irq_cause = 6'd5; step();
      irq_valid = 0; exc_valid = 1; exc_cause = 6'd8; step();
      idle(); cur_priv = 2'd3; deleg_s = 1; exc_valid = 1; step(); // M ignores deleg
      idle(); step();
      // random stretch
      for (int n = 0; n < 400; n++) begin
         rnmi_req  = NL'($urandom);
         irq_valid = ($urandom % 3) == 0;
         irq_cause = 6'($urandom);
         exc_valid = ($urandom % 5) == 0;
         exc_cause = 6'($urandom);
         exc_tval  = $urandom;
         deleg_s   = $urandom % 2;
         cur_pc    = $urandom & 32'hffff_fffc;
         case ($urandom % 3) 0: cur_priv = 2'd0; 1: cur_priv = 2'd1; default: cur_priv = 2'd3; endcase
         cur_virt  = $urandom % 2;
         mtvec     = $urandom & 32'hffff_fff1;
         stvec     = $urandom & 32'hffff_fff1;
         nmie_set  = ($urandom % 4) == 0;
         mie_set   = $urandom % 2;
         step();
      end
      idle(); step();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule